// File: doc/BRIEF.md
# Memory-Card Host Interrupt Router

This block keeps the pending-request and mask state for the interrupt sources of a memory-card host controller. It folds them into one processor interrupt line and two DMA request lines. Neighbouring logic (data path, command path, FIFOs) reports events as single-cycle set pulses. It also sends single-cycle clear pulses when a source is serviced, for example when a FIFO access retires the FIFO request. The bus decoder forwards writes to three registers: the interrupt mask, the clock start/stop control and the command/data configuration. The configuration register supplies only the DMA-enable bit.

When DMA mode is on, the two FIFO request sources no longer reach the processor interrupt. They drive the dedicated receive and transmit DMA request lines instead. A write to the clock control register turns the card clock status on or off and updates the clock-off request to match. All outputs are registered.

Top module: `cardirq_router`

## Requirements
- R1: After reset, every request bit and every mask bit is zero, the DMA mode is off, and `cpu_irq`, `rx_dma_req`, `tx_dma_req` and `clk_on` are low.
- R2: A 1 on `evt_set[k]` latches request k. The request positions are: 0 data done, 1 programming done, 2 command end, 3 stop command, 4 clock off, 5 receive FIFO request, 6 transmit FIFO request, 7 timeout, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 card acknowledge.
- R3: `cpu_irq` is high exactly when some latched request has its effective mask bit at 0. A mask bit of 1 blocks its request.
- R4: A mask write keeps only bits 12:0 of `mask_wdata`. Bits 31:13 have no effect on which requests reach `cpu_irq`.
- R5: When bit 7 of a configuration write is 1, DMA mode turns on. While DMA mode is on, requests 5 and 6 never raise `cpu_irq`, whatever their mask bits hold.
- R6: While DMA mode is on, `rx_dma_req` equals request 5 and `tx_dma_req` equals request 6.
- R7: While DMA mode is off, `rx_dma_req` and `tx_dma_req` are low.
- R8: A clock control write with bit 1 set and bit 0 clear sets `clk_on` and clears request 4.
- R9: A clock control write with bit 0 set clears `clk_on` and sets request 4. If bit 1 is also set in the same write, bit 0 wins.
- R10: Outputs change at the first clock edge after the event, write or clear that causes the change, and not before.
- R11: A 1 on `evt_clr[k]` clears request k. If a set and a clear hit the same bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set | input | 13 | Single-cycle request set pulses, one per source |
| evt_clr | input | 13 | Single-cycle request clear pulses, one per source |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 32 | Mask write data; bits 12:0 kept |
| clkctl_we | input | 1 | Clock control write strobe |
| clkctl_wdata | input | 2 | Bit 0 stop clock, bit 1 start clock |
| cfg_we | input | 1 | Command/data configuration write strobe |
| cfg_wdata | input | 16 | Configuration data; bit 7 is DMA enable |
| cpu_irq | output | 1 | Processor interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| clk_on | output | 1 | Card clock enabled status |

## Verification
The bound checker runs on every cycle and covers four properties. The DMA lines stay low outside DMA mode and track requests 5 and 6 inside it. An empty request set or a fully set mask never yields an interrupt. Set pulses always leave their requests latched. Each clock control write lands on `clk_on` and request 4 at the next edge. The bench scenarios cover what only a reference model can show: the exact interrupt value across mixtures of masks, DMA mode and clears, the discarded upper mask bits, set-over-clear priority, and the one-edge latency.

// File: rtl/cardirq_pkg.sv
package cardirq_pkg;
    localparam int NUM_SRC     = 13;
    localparam int IDX_DONE    = 0;
    localparam int IDX_CLKOFF  = 4;
    localparam int IDX_RXREQ   = 5;
    localparam int IDX_TXREQ   = 6;
    localparam int CTL_STOP    = 0;
    localparam int CTL_START   = 1;
    localparam int CTL_W       = 2;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t req;
    } req_state_t;

    typedef struct packed {
        src_vec_t mask;
        logic     dma;
        logic     clk_on;
    } ctrl_state_t;

    typedef struct packed {
        logic irq;
        logic rx;
        logic tx;
    } out_state_t;
endpackage

// File: rtl/cardirq_ctrl_regs.sv
module cardirq_ctrl_regs
    import cardirq_pkg::*;
#(
    parameter int MASK_WDATA_W = 32,
    parameter int CFG_W        = 16,
    parameter int DMA_BIT      = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mask_we,
    input  logic [MASK_WDATA_W-1:0] mask_wdata,
    input  logic                    clkctl_we,
    input  logic [CTL_W-1:0]        clkctl_wdata,
    input  logic                    cfg_we,
    input  logic [CFG_W-1:0]        cfg_wdata,
    output logic                    clk_start,
    output logic                    clk_stop,
    output ctrl_state_t             ctrl_d,
    output ctrl_state_t             ctrl_q
);
    localparam int UPPER_W = MASK_WDATA_W - NUM_SRC;

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^{mask_wdata[MASK_WDATA_W-1:NUM_SRC],
                                 cfg_wdata[CFG_W-1:DMA_BIT+1],
                                 cfg_wdata[DMA_BIT-1:0], UPPER_W[0]};

    always_comb begin
        clk_start = clkctl_we & clkctl_wdata[CTL_START];
        clk_stop  = clkctl_we & clkctl_wdata[CTL_STOP];
        ctrl_d    = ctrl_q;
        if (mask_we) begin
            ctrl_d.mask = mask_wdata[NUM_SRC-1:0];
        end
        if (cfg_we) begin
            ctrl_d.dma = cfg_wdata[DMA_BIT];
        end
        if (clk_start) begin
            ctrl_d.clk_on = 1'b1;
        end
        if (clk_stop) begin
            ctrl_d.clk_on = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/cardirq_req_bank.sv
module cardirq_req_bank
    import cardirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  src_vec_t   evt_set,
    input  src_vec_t   evt_clr,
    input  logic       clk_start,
    input  logic       clk_stop,
    output req_state_t req_d,
    output req_state_t req_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (i == IDX_CLKOFF) begin : g_clkoff
            always_comb begin
                if (clk_stop) begin
                    req_d.req[i] = 1'b1;
                end else if (clk_start) begin
                    req_d.req[i] = 1'b0;
                end else begin
                    req_d.req[i] = (req_q.req[i] & ~evt_clr[i]) | evt_set[i];
                end
            end
        end else begin : g_plain
            always_comb begin
                req_d.req[i] = (req_q.req[i] & ~evt_clr[i]) | evt_set[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end
endmodule

// File: rtl/cardirq_out_stage.sv
module cardirq_out_stage
    import cardirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  src_vec_t   req_nxt,
    input  src_vec_t   mask_nxt,
    input  logic       dma_nxt,
    output out_state_t out_q
);
    localparam src_vec_t FIFO_BITS = src_vec_t'((1 << IDX_RXREQ) | (1 << IDX_TXREQ));

    out_state_t out_d;
    src_vec_t   eff_mask;

    always_comb begin
        eff_mask  = mask_nxt | (dma_nxt ? FIFO_BITS : '0);
        out_d.irq = |(req_nxt & ~eff_mask);
        out_d.rx  = dma_nxt & req_nxt[IDX_RXREQ];
        out_d.tx  = dma_nxt & req_nxt[IDX_TXREQ];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end
endmodule

// File: rtl/cardirq_router.sv
module cardirq_router
    import cardirq_pkg::*;
#(
    parameter int MASK_WDATA_W = 32,
    parameter int CFG_W        = 16,
    parameter int DMA_BIT      = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      evt_set,
    input  logic [NUM_SRC-1:0]      evt_clr,
    input  logic                    mask_we,
    input  logic [MASK_WDATA_W-1:0] mask_wdata,
    input  logic                    clkctl_we,
    input  logic [CTL_W-1:0]        clkctl_wdata,
    input  logic                    cfg_we,
    input  logic [CFG_W-1:0]        cfg_wdata,
    output logic                    cpu_irq,
    output logic                    rx_dma_req,
    output logic                    tx_dma_req,
    output logic                    clk_on
);
    logic        clk_start;
    logic        clk_stop;
    ctrl_state_t ctrl_d;
    ctrl_state_t ctrl_q;
    req_state_t  req_d;
    req_state_t  req_q;
    out_state_t  out_q;

    cardirq_ctrl_regs #(
        .MASK_WDATA_W (MASK_WDATA_W),
        .CFG_W        (CFG_W),
        .DMA_BIT      (DMA_BIT)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_we      (mask_we),
        .mask_wdata   (mask_wdata),
        .clkctl_we    (clkctl_we),
        .clkctl_wdata (clkctl_wdata),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .clk_start    (clk_start),
        .clk_stop     (clk_stop),
        .ctrl_d       (ctrl_d),
        .ctrl_q       (ctrl_q)
    );

    cardirq_req_bank u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_set   (evt_set),
        .evt_clr   (evt_clr),
        .clk_start (clk_start),
        .clk_stop  (clk_stop),
        .req_d     (req_d),
        .req_q     (req_q)
    );

    cardirq_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_nxt  (req_d.req),
        .mask_nxt (ctrl_d.mask),
        .dma_nxt  (ctrl_d.dma),
        .out_q    (out_q)
    );

    assign cpu_irq    = out_q.irq;
    assign rx_dma_req = out_q.rx;
    assign tx_dma_req = out_q.tx;
    assign clk_on     = ctrl_q.clk_on;
endmodule

// File: rtl/cardirq_router_chk.sv
module cardirq_router_chk
    import cardirq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NUM_SRC-1:0] evt_set,
    input logic             clkctl_we,
    input logic [CTL_W-1:0] clkctl_wdata,
    input logic             cpu_irq,
    input logic             rx_dma_req,
    input logic             tx_dma_req,
    input logic             clk_on,
    input logic [NUM_SRC-1:0] req_vec,
    input logic [NUM_SRC-1:0] mask_vec,
    input logic             dma_mode
);
    localparam logic [NUM_SRC-1:0] NOT_CLKOFF = ~(NUM_SRC'(1) << IDX_CLKOFF);

    assert_dma_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode |-> (!rx_dma_req && !tx_dma_req));

    assert_dma_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_mode |-> (rx_dma_req == req_vec[IDX_RXREQ] && tx_dma_req == req_vec[IDX_TXREQ]));

    assert_idle_no_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vec == '0 || mask_vec == '1) |-> !cpu_irq);

    assert_set_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_set & NOT_CLKOFF) != '0) |=>
        ((req_vec & $past(evt_set & NOT_CLKOFF)) == $past(evt_set & NOT_CLKOFF)));

    assert_stop_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clkctl_we && clkctl_wdata[CTL_STOP]) |=> (!clk_on && req_vec[IDX_CLKOFF]));

    assert_start_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clkctl_we && clkctl_wdata[CTL_START] && !clkctl_wdata[CTL_STOP]) |=>
        (clk_on && !req_vec[IDX_CLKOFF]));
endmodule

bind cardirq_router cardirq_router_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_set      (evt_set),
    .clkctl_we    (clkctl_we),
    .clkctl_wdata (clkctl_wdata),
    .cpu_irq      (cpu_irq),
    .rx_dma_req   (rx_dma_req),
    .tx_dma_req   (tx_dma_req),
    .clk_on       (clk_on),
    .req_vec      (req_q.req),
    .mask_vec     (ctrl_q.mask),
    .dma_mode     (ctrl_q.dma)
);

// File: tb/sim_cardirq_router.sv
`timescale 1ns/1ps
module sim_cardirq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] evt_set = '0;
    logic [12:0] evt_clr = '0;
    logic        mask_we = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic        clkctl_we = 1'b0;
    logic [1:0]  clkctl_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        cpu_irq, rx_dma_req, tx_dma_req, clk_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [12:0] m_req = '0;
    logic [12:0] m_mask = '0;
    logic        m_dma = 1'b0;
    logic        m_clk = 1'b0;

    always #4 clk = ~clk;

    cardirq_router u0 (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .clkctl_we(clkctl_we), .clkctl_wdata(clkctl_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cpu_irq(cpu_irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .clk_on(clk_on)
    );

    function automatic logic exp_irq(logic [12:0] r, logic [12:0] m, logic d);
        logic [12:0] em;
        em = m | (d ? 13'h0060 : 13'h0000);
        return |(r & ~em);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        logic [12:0] r;
        r = (m_req & ~evt_clr) | evt_set;
        if (clkctl_we && clkctl_wdata[1]) begin r[4] = 1'b0; m_clk = 1'b1; end
        if (clkctl_we && clkctl_wdata[0]) begin r[4] = 1'b1; m_clk = 1'b0; end
        m_req = r;
        if (mask_we) m_mask = mask_wdata[12:0];
        if (cfg_we)  m_dma = cfg_wdata[7];
    endtask

    task automatic compare();
        logic ei;
        ei = exp_irq(m_req, m_mask, m_dma);
        check(cpu_irq == ei, m_dma ? "R5 irq" : "R3 irq", 32'(cpu_irq), 32'(ei));
        if (m_dma) begin
            check(rx_dma_req == m_req[5], "R6 rx", 32'(rx_dma_req), 32'(m_req[5]));
            check(tx_dma_req == m_req[6], "R6 tx", 32'(tx_dma_req), 32'(m_req[6]));
        end else begin
            check(!rx_dma_req && !tx_dma_req, "R7 dma lines",
                  32'({rx_dma_req, tx_dma_req}), 32'(0));
        end
        check(clk_on == m_clk, "R8 R9 clk_on", 32'(clk_on), 32'(m_clk));
    endtask

    task automatic clear_inputs();
        evt_set = '0; evt_clr = '0; mask_we = 0; clkctl_we = 0; cfg_we = 0;
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        clear_inputs();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check({cpu_irq, rx_dma_req, tx_dma_req, clk_on} == 4'b0, "R1 outputs",
              32'({cpu_irq, rx_dma_req, tx_dma_req, clk_on}), 32'(0));
        rst_n = 1'b1;
        @(negedge clk);
        compare();

        // R2: data-done event raises irq with empty mask
        evt_set = 13'h0001; step();
        check(cpu_irq == 1'b1, "R2 data done", 32'(cpu_irq), 32'(1));

        // R4: upper mask bits discarded, bit 0 stays unmasked
        mask_we = 1'b1; mask_wdata = 32'hFFFF_E000; step();
        check(cpu_irq == 1'b1, "R4 upper bits", 32'(cpu_irq), 32'(1));
        // R3: masking bit 0 silences it
        mask_we = 1'b1; mask_wdata = 32'h0000_0001; step();
        check(cpu_irq == 1'b0, "R3 masked", 32'(cpu_irq), 32'(0));

        // R11: set and clear in same cycle keep the bit (bit 9)
        mask_we = 1'b1; mask_wdata = 32'h0; evt_clr = 13'h1FFF; step();
        evt_set = 13'h0200; evt_clr = 13'h0200; step();
        check(cpu_irq == 1'b1, "R11 set wins", 32'(cpu_irq), 32'(1));
        evt_clr = 13'h0200; step();
        check(cpu_irq == 1'b0, "R11 clear", 32'(cpu_irq), 32'(0));

        // R10: output unchanged before the edge, changed after
        evt_set = 13'h0100;
        #1;
        check(cpu_irq == 1'b0, "R10 before edge", 32'(cpu_irq), 32'(0));
        step();
        check(cpu_irq == 1'b1, "R10 after edge", 32'(cpu_irq), 32'(1));
        evt_clr = 13'h0100; step();

        // R8: start clock; R9: both bits -> stop wins
        clkctl_we = 1'b1; clkctl_wdata = 2'b10; step();
        check(clk_on == 1'b1 && cpu_irq == 1'b0, "R8 start",
              32'({clk_on, cpu_irq}), 32'(2));
        clkctl_we = 1'b1; clkctl_wdata = 2'b11; step();
        check(clk_on == 1'b0 && cpu_irq == 1'b1, "R9 stop wins",
              32'({clk_on, cpu_irq}), 32'(1));
        clkctl_we = 1'b1; clkctl_wdata = 2'b10; step();

        // R5/R6: DMA mode diverts FIFO requests
        cfg_we = 1'b1; cfg_wdata = 16'h0080; evt_set = 13'h0060; step();
        check(cpu_irq == 1'b0 && rx_dma_req && tx_dma_req, "R5 R6 dma divert",
              32'({cpu_irq, rx_dma_req, tx_dma_req}), 32'(3));
        // R7: DMA off releases lines, FIFO requests reach irq
        cfg_we = 1'b1; cfg_wdata = 16'hFF7F; step();
        check(cpu_irq == 1'b1 && !rx_dma_req && !tx_dma_req, "R7 dma off",
              32'({cpu_irq, rx_dma_req, tx_dma_req}), 32'(4));

        // random mix
        for (int n = 0; n < 3000; n++) begin
            evt_set = 13'($urandom & $urandom & $urandom);
            evt_clr = 13'($urandom & $urandom);
            if (($urandom % 8) == 0) begin mask_we = 1'b1; mask_wdata = $urandom; end
            if (($urandom % 12) == 0) begin cfg_we = 1'b1; cfg_wdata = 16'($urandom); end
            if (($urandom % 12) == 0) begin clkctl_we = 1'b1; clkctl_wdata = 2'($urandom); end
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule